// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Controller

This block drives a small three-wire serial EEPROM of 64 words, each 16 bits wide. A host raises a read request or a write request for one cycle with a word address and, for writes, a data word. The controller then produces every pin transition on its own. That covers the select/clock framing, the command bits, the data bits, the enable and disable commands around a write, and the wait for the end of the device's internal programming cycle. While it works it holds busy high. When it finishes it pulses done for one cycle, and it presents the read word or the timeout result alongside that pulse.

All pin timing is built from one half-period, which is a parameter counted in system clock cycles. Every select, clock and data change lasts a whole number of half-periods. The memory's data output is sampled only at the end of a half-period. A write that the device never acknowledges is abandoned after a bounded number of polls. The controller still sends the disable command and the closing clock pulse in that case, so the device is left protected.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: While reset is held, and after it is released, select, clock, data-in, busy, done and timeout are all low.
- R2: A read sends the bits 1,1,0 and then the 6-bit address, most significant bit first. It then raises the clock 16 times and samples data-out one half-period after each rising edge. It assembles the word with the first sample as bit 15 and returns the addressed word on the read data output.
- R3: Before its write command, a write sends 1,0,0,1,1 followed by four 0 bits. The write command is 1,0,1, the 6-bit address and the 16 data bits, all most significant bit first. After the write the controller sends 1,0,0,0,0 followed by four 0 bits. The device ends up holding the new word, and writes are disabled again afterwards.
- R4: Data-in stays low for the whole 16-bit shift-in of a read.
- R5: Every clock pulse taken while select is high lasts exactly one half-period. Data-in has been stable for at least one half-period before that rising edge.
- R6: Commands are separated by a standby sequence in four half-periods: select and clock low; clock high; select high; clock low. A read ends with one standby. A write contains three.
- R7: After a write command, data-out is sampled once per half-period. The first high sample ends the wait, and the operation then completes with timeout low.
- R8: If data-out is still low after 200 samples, timeout is reported high with done. The disable command and the closing pulse are still sent.
- R9: Done is high for exactly one cycle. Busy is low in that same cycle.
- R10: Requests and the address and data inputs have no effect while busy is high.
- R11: If read and write requests arrive in the same cycle, only the read is performed.
- R12: A write ends by dropping select and data-in and then giving one full clock pulse with select low. A read has no such pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req_i | input | 1 | Read request, taken while busy is low |
| wr_req_i | input | 1 | Write request, taken while busy is low |
| addr_i | input | 6 | Word address |
| wdata_i | input | 16 | Word to write |
| rdata_o | output | 16 | Word returned by the last read |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| timeout_o | output | 1 | Last write was never acknowledged |
| ee_cs_o | output | 1 | Memory select |
| ee_sk_o | output | 1 | Memory serial clock |
| ee_di_o | output | 1 | Serial data to the memory |
| ee_do_i | input | 1 | Serial data from the memory |

## Verification
If the sequence index is wrong, the pins show it during the same operation. The device model sees a wrong number of standby toggles or low-select clock pulses, a missing enable, or writes left enabled, all before done. If a bit or phase counter is wrong, the word lands at the wrong address, or a read returns a shifted or corrupted word. That shows at the next read-back. A fault in the half-period timer breaks the pulse-width or setup measurement at the first clock edge taken with select high.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    SK_SETUP, SK_OUT, SK_IN, SK_STBY, SK_POLL, SK_CLEAN, SK_END
  } seg_kind_e;

  typedef enum logic [1:0] {PL_NONE, PL_WEN, PL_CMD, PL_WDS} pay_e;

  typedef struct packed {
    seg_kind_e kind;
    pay_e      pay;
  } seg_t;

  typedef struct packed {
    logic cs;
    logic sk;
    logic di;
  } pins_t;

  localparam logic [2:0] OPC_RD  = 3'b110;
  localparam logic [2:0] OPC_WR  = 3'b101;
  localparam logic [4:0] OPC_WEN = 5'b10011;
  localparam logic [4:0] OPC_WDS = 5'b10000;

  // Ordered program of segments for each operation kind.
  function automatic seg_t seg_lookup(input logic wr, input logic [3:0] idx);
    seg_t s;
    s.kind = SK_END;
    s.pay  = PL_NONE;
    if (!wr) begin
      case (idx)
        4'd0: s.kind = SK_SETUP;
        4'd1: begin s.kind = SK_OUT; s.pay = PL_CMD; end
        4'd2: s.kind = SK_IN;
        4'd3: s.kind = SK_STBY;
        default: s.kind = SK_END;
      endcase
    end else begin
      case (idx)
        4'd0: s.kind = SK_SETUP;
        4'd1: begin s.kind = SK_OUT; s.pay = PL_WEN; end
        4'd2: s.kind = SK_STBY;
        4'd3: begin s.kind = SK_OUT; s.pay = PL_CMD; end
        4'd4: s.kind = SK_STBY;
        4'd5: s.kind = SK_POLL;
        4'd6: s.kind = SK_STBY;
        4'd7: begin s.kind = SK_OUT; s.pay = PL_WDS; end
        4'd8: s.kind = SK_CLEAN;
        default: s.kind = SK_END;
      endcase
    end
    return s;
  endfunction

  // Pin levels held during one half-period of a segment.
  function automatic pins_t pin_decode(input seg_kind_e k, input logic [1:0] ph,
                                       input logic b);
    pins_t p;
    p.cs = 1'b0;
    p.sk = 1'b0;
    p.di = 1'b0;
    case (k)
      SK_SETUP: p.cs = (ph == 2'd1);
      SK_OUT: begin
        p.cs = 1'b1;
        p.sk = (ph == 2'd1);
        p.di = (ph != 2'd2) && b;
      end
      SK_IN: begin
        p.cs = 1'b1;
        p.sk = (ph == 2'd0);
      end
      SK_STBY: begin
        p.cs = (ph >= 2'd2);
        p.sk = (ph == 2'd1) || (ph == 2'd2);
      end
      SK_POLL:  p.cs = 1'b1;
      SK_CLEAN: p.sk = (ph == 2'd1);
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/mw_halftick.sv
module mw_halftick #(
  parameter int HALF_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(HALF_CYC + 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // R5: the half-period counter never passes its terminal count
  a_r5_tick_bound: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < CW'(HALF_CYC)));

endmodule

// File: rtl/mw_shreg.sv
module mw_shreg #(
  parameter int PW = 25,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  input  logic          adv,
  input  logic          cap,
  input  logic          cap_bit,
  output logic [1:0]    out_hi,
  output logic [DW-1:0] cap_word
);
  logic [PW-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)       sr <= '0;
    else if (load) sr <= load_val;
    else if (adv)  sr <= {sr[PW-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst)      cap_word <= '0;
    else if (cap) cap_word <= {cap_word[DW-2:0], cap_bit};
  end

  assign out_hi = sr[PW-1 -: 2];

  // R2: no load and shift in the same cycle
  a_r2_load_excl: assert property (@(posedge clk) disable iff (rst)
    load |-> !adv);

endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
  import mw_pkg::*;
#(
  parameter int AW       = 6,
  parameter int DW       = 16,
  parameter int HALF_CYC = 8,
  parameter int POLL_MAX = 200
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_req_i,
  input  logic          wr_req_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          timeout_o,
  output logic          ee_cs_o,
  output logic          ee_sk_o,
  output logic          ee_di_o,
  input  logic          ee_do_i
);
  localparam int PW  = 3 + AW + DW;   // longest frame: write command
  localparam int CB  = 3 + AW;        // read command and enable/disable frames
  localparam int BCW = $clog2(PW + 1);
  localparam int PCW = $clog2(POLL_MAX + 1);

  logic           busy_q, done_q, tmo_q, op_wr_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q, rdata_q;
  logic [3:0]     seg_idx_q, n_idx;
  logic [1:0]     phase_q, n_ph;
  logic [BCW-1:0] bitcnt_q, n_bit, cur_last;
  logic [PCW-1:0] pollcnt_q, n_poll;
  logic           cs_q, sk_q, di_q;

  logic           tick, adv, sh_out, sh_in, set_tmo, load, finish, bitval;
  logic [1:0]     out_hi;
  logic [DW-1:0]  rx_word;
  logic [PW-1:0]  aligned;
  seg_t           cur, nxt;
  seg_kind_e      n_kind;
  pins_t          pin_nxt;

  mw_halftick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk(clk), .rst(rst), .run(busy_q), .tick(tick)
  );

  mw_shreg #(.PW(PW), .DW(DW)) u_shreg (
    .clk(clk), .rst(rst), .load(load), .load_val(aligned), .adv(sh_out),
    .cap(sh_in), .cap_bit(ee_do_i), .out_hi(out_hi), .cap_word(rx_word)
  );

  assign cur = seg_lookup(op_wr_q, seg_idx_q);
  assign nxt = seg_lookup(op_wr_q, seg_idx_q + 4'd1);

  // Frame contents, left-aligned so the first bit to send is the MSB
  always_comb begin
    case (nxt.pay)
      PL_WEN:  aligned = {OPC_WEN, {(PW-5){1'b0}}};
      PL_WDS:  aligned = {OPC_WDS, {(PW-5){1'b0}}};
      PL_CMD:  aligned = op_wr_q ? {OPC_WR, addr_q, wdata_q}
                                 : {OPC_RD, addr_q, {DW{1'b0}}};
      default: aligned = '0;
    endcase
    cur_last = (cur.pay == PL_CMD && op_wr_q) ? BCW'(PW - 1) : BCW'(CB - 1);
  end

  // Segment and phase stepping, one step per half-period
  always_comb begin
    n_idx   = seg_idx_q;
    n_ph    = phase_q;
    n_bit   = bitcnt_q;
    n_poll  = pollcnt_q;
    adv     = 1'b0;
    sh_out  = 1'b0;
    sh_in   = 1'b0;
    set_tmo = 1'b0;
    if (busy_q && tick) begin
      case (cur.kind)
        SK_SETUP: if (phase_q == 2'd0) n_ph = 2'd1; else adv = 1'b1;
        SK_OUT: begin
          if (phase_q != 2'd2)          n_ph = phase_q + 2'd1;
          else if (bitcnt_q == cur_last) adv = 1'b1;
          else begin
            n_ph   = 2'd0;
            n_bit  = bitcnt_q + 1'b1;
            sh_out = 1'b1;
          end
        end
        SK_IN: begin
          if (phase_q == 2'd0) begin
            n_ph  = 2'd1;
            sh_in = 1'b1;
          end else if (bitcnt_q == BCW'(DW - 1)) adv = 1'b1;
          else begin
            n_ph  = 2'd0;
            n_bit = bitcnt_q + 1'b1;
          end
        end
        SK_STBY:  if (phase_q != 2'd3) n_ph = phase_q + 2'd1; else adv = 1'b1;
        SK_POLL: begin
          if (ee_do_i) adv = 1'b1;
          else if (pollcnt_q == PCW'(POLL_MAX - 1)) begin
            adv     = 1'b1;
            set_tmo = 1'b1;
          end else n_poll = pollcnt_q + 1'b1;
        end
        SK_CLEAN: if (phase_q != 2'd2) n_ph = phase_q + 2'd1; else adv = 1'b1;
        default:  adv = 1'b1;
      endcase
    end
    if (adv) begin
      n_idx  = seg_idx_q + 4'd1;
      n_ph   = 2'd0;
      n_bit  = '0;
      n_poll = '0;
    end
  end

  assign n_kind  = adv ? nxt.kind : cur.kind;
  assign load    = adv && (nxt.kind == SK_OUT);
  assign finish  = adv && (nxt.kind == SK_END);
  assign bitval  = load ? aligned[PW-1] : (sh_out ? out_hi[0] : out_hi[1]);
  assign pin_nxt = pin_decode(n_kind, n_ph, bitval);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      tmo_q     <= 1'b0;
      op_wr_q   <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      seg_idx_q <= '0;
      phase_q   <= '0;
      bitcnt_q  <= '0;
      pollcnt_q <= '0;
      cs_q      <= 1'b0;
      sk_q      <= 1'b0;
      di_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (rd_req_i || wr_req_i) begin
          busy_q    <= 1'b1;
          op_wr_q   <= !rd_req_i;        // read wins a tie
          addr_q    <= addr_i;
          wdata_q   <= wdata_i;
          tmo_q     <= 1'b0;
          seg_idx_q <= '0;
          phase_q   <= '0;
          bitcnt_q  <= '0;
          pollcnt_q <= '0;
        end
      end else begin
        seg_idx_q <= n_idx;
        phase_q   <= n_ph;
        bitcnt_q  <= n_bit;
        pollcnt_q <= n_poll;
        {cs_q, sk_q, di_q} <= pin_nxt;
        if (set_tmo) tmo_q <= 1'b1;
        if (finish) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          if (!op_wr_q) rdata_q <= rx_word;
        end
      end
    end
  end

  assign rdata_o   = rdata_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign timeout_o = tmo_q;
  assign ee_cs_o   = cs_q;
  assign ee_sk_o   = sk_q;
  assign ee_di_o   = di_q;

  // R9: done lasts a single cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R9: busy only ends together with done
  a_r9_busy_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);
  // R1: pins are quiet whenever no operation runs
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!ee_cs_o && !ee_sk_o && !ee_di_o));
  // R4: data-in low throughout the shift-in segment
  a_r4_di_low_in: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cur.kind == SK_IN) |-> !ee_di_o);
  // R5: clock rises with select high only in data-carrying segments
  a_r5_sk_with_cs: assert property (@(posedge clk) disable iff (rst)
    ($rose(ee_sk_o) && ee_cs_o) |-> (cur.kind == SK_OUT || cur.kind == SK_IN));
  // R8: a read never reports a timeout
  a_r8_tmo_write_only: assert property (@(posedge clk) disable iff (rst)
    (done_o && !op_wr_q) |-> !timeout_o);
  // R10: latched request fields hold during an operation
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> ($stable(addr_q) && $stable(op_wr_q) && $stable(wdata_q)));

endmodule

// File: tb/mw_eeprom_ctrl_bench.sv
module mw_eeprom_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;
  localparam int POLLN      = 200;
  localparam int PROG_DLY   = 120;
  localparam int M_IDLE = 0, M_CMD = 1, M_DATA = 2, M_STAT = 3;

  logic clk = 1'b0, rst = 1'b1, rd_req = 1'b0, wr_req = 1'b0;
  logic [5:0]  addr  = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic busy, done, tmo, cs, sk, di;
  logic ee_do;

  int total = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom_ctrl #(.AW(6), .DW(16), .HALF_CYC(HALF), .POLL_MAX(POLLN)) u_mw_eeprom_ctrl (
    .clk(clk), .rst(rst), .rd_req_i(rd_req), .wr_req_i(wr_req), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy), .done_o(done), .timeout_o(tmo),
    .ee_cs_o(cs), .ee_sk_o(sk), .ee_di_o(di), .ee_do_i(ee_do)
  );

  function automatic logic [15:0] init_word(input int i);
    return 16'((i * 40503) ^ 23130);
  endfunction

  // ---------------- device model (observes pins only) ----------------
  logic [15:0] mem [64];
  logic [15:0] exp_mem [64];
  logic [24:0] sh;
  logic [15:0] word, wd;
  logic [5:0]  wa;
  int  mode, bitn, k, prog_cnt, di_st, sk_len;
  bit  wen, prog_active, wr_pend, hi_cs, cs_p, sk_p, di_p;
  bit  stuck = 1'b0, mon_clr = 1'b0;
  int  n_stby, n_sklow, n_di_in, n_tv;

  always @(posedge clk) begin
    if (rst || mon_clr) begin
      n_stby = 0; n_sklow = 0; n_di_in = 0; n_tv = 0;
    end
    if (rst) begin
      for (int i = 0; i < 64; i++) mem[i] = init_word(i);
      mode = M_IDLE; wen = 0; prog_active = 0; prog_cnt = 0; wr_pend = 0;
      cs_p = 0; sk_p = 0; di_p = 0; di_st = 0; sk_len = 0; hi_cs = 0;
      bitn = 0; k = 0; sh = '0;
      ee_do <= 1'b0;
    end else begin
      if (prog_cnt > 0) prog_cnt--;
      if (di != di_p) di_st = 1; else if (di_st < 100000) di_st++;
      if (sk && !sk_p) begin
        sk_len = 1; hi_cs = cs;
        if (cs) begin if (di_st <= HALF) n_tv++; end
        else n_sklow++;
      end else if (sk) sk_len++;
      if (!sk && sk_p && hi_cs && sk_len != HALF) n_tv++;
      if (cs && !cs_p && sk) n_stby++;
      if (cs && !cs_p) begin
        bitn = 0; sh = '0;
        mode = prog_active ? M_STAT : M_CMD;
      end
      if (!cs && cs_p) begin
        if (mode == M_CMD && wr_pend && wen) begin
          if (!stuck) mem[wa] = wd;
          prog_active = 1; prog_cnt = PROG_DLY;
        end else if (mode == M_STAT) prog_active = 0;
        wr_pend = 0; mode = M_IDLE;
        ee_do <= 1'b0;
      end
      if (sk && !sk_p && cs) begin
        if (mode == M_CMD) begin
          sh = {sh[23:0], di}; bitn++;
          if (bitn == 9) begin
            if (sh[8:6] == 3'b110) begin mode = M_DATA; word = mem[sh[5:0]]; k = 0; end
            if (sh[8:4] == 5'b10011) wen = 1;
            if (sh[8:4] == 5'b10000) wen = 0;
          end
          if (bitn == 25 && sh[24:22] == 3'b101) begin
            wr_pend = 1; wa = sh[21:16]; wd = sh[15:0];
          end
        end else if (mode == M_DATA) begin
          if (di) n_di_in++;
          if (k < 16) ee_do <= word[15-k];
          k++;
        end
      end
      if (mode == M_STAT && cs) ee_do <= (prog_cnt == 0) && !stuck;
      cs_p = cs; sk_p = sk; di_p = di;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic run_op(input bit wr, input bit both, input logic [5:0] a,
                        input logic [15:0] d, input bit poke,
                        output logic [15:0] rd, output bit err, output int lat);
    int cnt;
    @(negedge clk);
    while (busy) @(negedge clk);
    mon_clr = 1; addr = a; wdata = d;
    rd_req = !wr || both; wr_req = wr || both;
    @(negedge clk);
    mon_clr = 0; rd_req = 0; wr_req = 0;
    cnt = 0;
    while (!done && cnt < 50000) begin
      if (poke && cnt == 60) begin
        addr = a ^ 6'h01; wdata = ~d; wr_req = 1; rd_req = 1;
      end else begin
        wr_req = 0; rd_req = 0;
      end
      @(negedge clk); cnt++;
    end
    wr_req = 0; rd_req = 0;
    chk(cnt < 50000, "R9", "operation finished", cnt, 50000);
    lat = cnt; rd = rdata; err = tmo;
    chk(busy == 0, "R9", "busy low with done", busy, 0);
    @(negedge clk);
    chk(done == 0, "R9", "done lasts one cycle", done, 0);
  endtask

  task automatic do_read(input logic [5:0] a, input string rq);
    logic [15:0] r; bit e; int l;
    run_op(0, 0, a, 16'h0, 0, r, e, l);
    chk(r == exp_mem[a], rq, "read word", r, exp_mem[a]);
    chk(n_di_in == 0, "R4", "di high during shift-in", n_di_in, 0);
    chk(n_stby == 1, "R6", "standby count on read", n_stby, 1);
    chk(n_sklow == 1, "R12", "no cleanup pulse on read", n_sklow, 1);
    chk(n_tv == 0, "R5", "bit timing violations", n_tv, 0);
    chk(e == 0, "R8", "no timeout on read", e, 0);
  endtask

  task automatic do_write(input logic [5:0] a, input logic [15:0] d, input bit poke);
    logic [15:0] r; bit e; int l;
    run_op(1, 0, a, d, poke, r, e, l);
    exp_mem[a] = d;
    chk(e == 0, "R7", "acknowledged write timeout flag", e, 0);
    chk(wen == 0, "R3", "writes disabled after write", wen, 0);
    chk(n_stby == 3, "R6", "standby count on write", n_stby, 3);
    chk(n_sklow == 4, "R12", "low-select pulses on write", n_sklow, 4);
    chk(n_tv == 0, "R5", "bit timing violations", n_tv, 0);
  endtask

  initial begin
    logic [15:0] r; bit e; int l;
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    for (int i = 0; i < 64; i++) exp_mem[i] = init_word(i);
    repeat (4) @(negedge clk);
    // R1: state during reset
    chk(cs == 0 && sk == 0 && di == 0, "R1", "pins in reset", {cs, sk, di}, 0);
    chk(busy == 0 && done == 0 && tmo == 0, "R1", "status in reset", {busy, done, tmo}, 0);
    rst = 0;
    repeat (3) @(negedge clk);
    chk(cs == 0 && sk == 0 && di == 0, "R1", "pins after reset", {cs, sk, di}, 0);
    chk(busy == 0, "R1", "busy after reset", busy, 0);
    chk(done == 0 && tmo == 0, "R1", "done/timeout after reset", {done, tmo}, 0);

    // R2: directed reads at both address ends
    do_read(6'd0, "R2");
    do_read(6'd63, "R2");
    // R3, R7: directed writes of extreme patterns with read-back
    do_write(6'd63, 16'hFFFF, 0);
    do_read(6'd63, "R3");
    do_write(6'd0, 16'h0000, 0);
    do_read(6'd0, "R3");
    do_write(6'd21, 16'hA5C3, 0);
    do_read(6'd21, "R3");

    // R11: simultaneous requests perform only the read
    run_op(0, 1, 6'd5, 16'h1234, 0, r, e, l);
    chk(r == exp_mem[5], "R11", "read taken on tie", r, exp_mem[5]);
    chk(n_stby == 1, "R11", "tie ran a read frame", n_stby, 1);
    do_read(6'd5, "R11");

    // R10: requests mid-operation are ignored
    do_write(6'd10, 16'h3C3C, 1);
    do_read(6'd10, "R10");
    do_read(6'd11, "R10");

    // R8: device never acknowledges
    stuck = 1;
    run_op(1, 0, 6'd30, 16'hBEEF, 0, r, e, l);
    chk(e == 1, "R8", "timeout reported", e, 1);
    chk(l > POLLN * HALF, "R8", "poll window length", l, POLLN * HALF);
    chk(wen == 0, "R8", "disable sent after timeout", wen, 0);
    chk(n_sklow == 4, "R8", "cleanup pulse after timeout", n_sklow, 4);
    stuck = 0;
    do_read(6'd30, "R8");
    do_write(6'd30, 16'h0F0F, 0);
    do_read(6'd30, "R7");

    // mixed random operations
    for (int n = 0; n < 24; n++) begin
      logic [5:0] ra; logic [15:0] rdv;
      ra  = 6'($urandom % 64);
      rdv = 16'($urandom);
      if ($urandom % 2) do_write(ra, rdv, 0);
      else              do_read(ra, "R2");
    end
    for (int i = 0; i < 64; i += 9) do_read(6'(i), "R3");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    total++; fails++;
    $display("FAIL R9 watchdog: actual %0d expected %0d", 195000, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule